// File: doc/BRIEF.md
# DRAM initialization and refresh sequencer

This block sits on the controller side of a four-bank synchronous DRAM. It drives the command lines (chip select, row strobe, column strobe, write enable), the eleven-bit address bus and the bank-select bus. After reset it brings the memory up in a fixed order. First it waits with no-operation commands. Then it closes every bank, runs two refresh cycles and programs the mode word. It then reports that initialization is complete.

Once initialized, the block keeps the array refreshed. A free-running interval counter requests a refresh once per `REF_INTERVAL` clocks. The default is chosen so that at least 4096 refreshes land in every 64 ms, with some margin. Each refresh is issued as a precharge-all followed by an auto-refresh, so every bank is closed when the refresh is registered.

Between refreshes, a simple request/grant port lets the rest of the controller use the memory. A pending or running refresh always wins over that port. All waits are clock-count parameters.

Top module: `dram_init_refresh_seq`

## Requirements
- R1: Every cycle the command lines {cs_n, ras_n, cas_n, we_n} carry one of these codes: no-op 0111, precharge 0010, auto-refresh 0001, load-mode 0000. Chip select is never left high.
- R2: After reset is released, only no-op is driven for `INIT_WAIT` cycles. The first other command appears in cycle `INIT_WAIT`, counting the first clock edge after release as cycle 1.
- R3: The power-up commands come in this order: precharge with address bit 10 high (all banks), auto-refresh, auto-refresh, load-mode. The bank outputs are 0 and all other address bits are 0 on precharge and refresh.
- R4: The command after a precharge-all comes exactly `T_RP` cycles later, and the command after an auto-refresh comes exactly `T_RC` cycles later, with only no-ops in between.
- R5: The load-mode address carries the mode word. Bits 2:0 hold the burst-length code (1→000, 2→001, 4→010, 8→011, full page→111). Bit 3 is the burst type (1 = interleaved). Bits 6:4 hold the CAS latency (010 for 2, 011 for 3). Bits 8:7 are 00. Bit 9 is the write mode (1 = single-location writes). Bit 10 is 0.
- R6: `init_done` rises exactly `T_MRD` cycles after the load-mode command, stays low before that, and stays high until the next reset.
- R7: After `init_done` rises in cycle D, a precharge-all appears in cycle D + n·`REF_INTERVAL` for n = 1, 2, … Each is followed `T_RP` cycles later by an auto-refresh.
- R8: Once initialized and with no refresh activity, `usr_gnt` in cycle k equals `usr_req` as sampled at the edge that starts cycle k. Before `init_done`, `usr_gnt` is 0.
- R9: Refresh has priority. `usr_gnt` is 0 from the cycle the refresh precharge-all appears until `T_RP`+`T_RC` cycles later, even with `usr_req` held high, and returns in the first cycle after that.
- R10: While reset is held, the outputs show no-op, address 0, bank 0, `init_done` 0 and `usr_gnt` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_req | input | 1 | User request for memory access |
| usr_gnt | output | 1 | User access granted this cycle |
| init_done | output | 1 | Power-up sequence finished |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_addr | output | ADDR_W | Address / mode word |
| sdr_bank | output | BANK_W | Bank select |

## Verification
Every command leaves a register, so a command decided at edge k shows on the pins in cycle k. A wait of T cycles therefore places the next command exactly T cycles after the previous one.

The bench works out each command's cycle from the parameters. The power-up commands fall at INIT_WAIT, +T_RP, +T_RC and +T_RC again. `init_done` follows T_MRD later, and refreshes come every REF_INTERVAL after that. These expected commands are queued with their cycle numbers, and the monitor compares every non-no-op command against the head of the queue.

The grant is registered, so the monitor compares it one cycle after the request was driven. It expects a low grant during each refresh window, which is T_RP+T_RC cycles long starting at the precharge. All sampling happens at the falling edge.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    // Command code as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_BST  = 4'b0110,
        CMD_NOP  = 4'b0111,
        CMD_INH  = 4'b1111
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_POWER     = 3'd0,
        ST_PRE_WAIT  = 3'd1,
        ST_REF_WAIT  = 3'd2,
        ST_MODE_WAIT = 3'd3,
        ST_RUN       = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dram_refresh_tick.sv
module dram_refresh_tick #(
    parameter int INTERVAL = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = RELOAD;
        end else if (cnt_q == '0) begin
            cnt_d = RELOAD;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    generate
        if (INTERVAL > 1) begin : g_spacing
            // R7: two refresh requests are never back to back
            a_r7_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/dram_mode_word.sv
module dram_mode_word #(
    parameter int ADDR_W       = 11,
    parameter int BURST_LEN    = 8,
    parameter bit INTERLEAVE   = 1'b0,
    parameter int CAS_LAT      = 3,
    parameter bit SINGLE_WRITE = 1'b0
) (
    output logic [ADDR_W-1:0] word
);
    logic [2:0] len_code;
    logic [2:0] lat_code;

    generate
        if (BURST_LEN == 1) begin : g_bl1
            assign len_code = 3'b000;
        end else if (BURST_LEN == 2) begin : g_bl2
            assign len_code = 3'b001;
        end else if (BURST_LEN == 4) begin : g_bl4
            assign len_code = 3'b010;
        end else if (BURST_LEN == 8) begin : g_bl8
            assign len_code = 3'b011;
        end else begin : g_blpage
            assign len_code = 3'b111;
        end

        if (CAS_LAT == 2) begin : g_cl2
            assign lat_code = 3'b010;
        end else begin : g_cl3
            assign lat_code = 3'b011;
        end
    endgenerate

    assign word = ADDR_W'({SINGLE_WRITE, 2'b00, lat_code, INTERLEAVE, len_code});

endmodule

// File: rtl/dram_init_refresh_seq.sv
module dram_init_refresh_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int BANK_W       = 2,
    parameter int INIT_WAIT    = 10000,
    parameter int T_RP         = 2,
    parameter int T_RC         = 7,
    parameter int T_MRD        = 2,
    parameter int REF_INTERVAL = 1500,
    parameter int BURST_LEN    = 8,
    parameter bit INTERLEAVE   = 1'b0,
    parameter int CAS_LAT      = 3,
    parameter bit SINGLE_WRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_req,
    output logic              usr_gnt,
    output logic              init_done,
    output logic              sdr_cs_n,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic [BANK_W-1:0] sdr_bank
);
    localparam int MAX_A  = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int MAX_B  = (MAX_A > T_MRD) ? MAX_A : T_MRD;
    localparam int MAX_T  = (MAX_B > INIT_WAIT) ? MAX_B : INIT_WAIT;
    localparam int CNT_W  = $clog2(MAX_T + 1);

    localparam logic [CNT_W-1:0]  INIT_LOAD = CNT_W'(INIT_WAIT - 1);
    localparam logic [CNT_W-1:0]  RP_LOAD   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0]  RC_LOAD   = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0]  MRD_LOAD  = CNT_W'(T_MRD - 1);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1024);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              second_ref;
        logic              done;
        logic              pend;
        logic              gnt;
        dram_cmd_e         cmd;
        logic [ADDR_W-1:0] addr;
    } seq_regs_t;

    seq_regs_t         d, q;
    logic              ref_tick;
    logic [ADDR_W-1:0] mode_word;

    dram_refresh_tick #(
        .INTERVAL (REF_INTERVAL)
    ) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.done),
        .tick  (ref_tick)
    );

    dram_mode_word #(
        .ADDR_W       (ADDR_W),
        .BURST_LEN    (BURST_LEN),
        .INTERLEAVE   (INTERLEAVE),
        .CAS_LAT      (CAS_LAT),
        .SINGLE_WRITE (SINGLE_WRITE)
    ) i_mode (
        .word (mode_word)
    );

    always_comb begin
        d      = q;
        d.cmd  = CMD_NOP;
        d.addr = '0;
        if (ref_tick) d.pend = 1'b1;

        unique case (q.state)
            ST_POWER: begin
                if (q.cnt == '0) begin
                    d.cmd   = CMD_PRE;
                    d.addr  = ALL_BANKS;
                    d.state = ST_PRE_WAIT;
                    d.cnt   = RP_LOAD;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_PRE_WAIT: begin
                if (q.cnt == '0) begin
                    d.cmd   = CMD_REF;
                    d.state = ST_REF_WAIT;
                    d.cnt   = RC_LOAD;
                    if (q.done) d.pend = ref_tick;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_REF_WAIT: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.done) begin
                    d.state = ST_RUN;
                end else if (!q.second_ref) begin
                    d.cmd        = CMD_REF;
                    d.second_ref = 1'b1;
                    d.cnt        = RC_LOAD;
                end else begin
                    d.cmd   = CMD_LMR;
                    d.addr  = mode_word;
                    d.state = ST_MODE_WAIT;
                    d.cnt   = MRD_LOAD;
                end
            end
            ST_MODE_WAIT: begin
                if (q.cnt == '0) begin
                    d.state = ST_RUN;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RUN: begin
                if (q.pend || ref_tick) begin
                    d.cmd   = CMD_PRE;
                    d.addr  = ALL_BANKS;
                    d.state = ST_PRE_WAIT;
                    d.cnt   = RP_LOAD;
                end
            end
            default: d.state = ST_POWER;
        endcase

        d.gnt = usr_req && d.done && (d.state == ST_RUN) && !d.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state      <= ST_POWER;
            q.cnt        <= INIT_LOAD;
            q.second_ref <= 1'b0;
            q.done       <= 1'b0;
            q.pend       <= 1'b0;
            q.gnt        <= 1'b0;
            q.cmd        <= CMD_NOP;
            q.addr       <= '0;
        end else begin
            q <= d;
        end
    end

    assign {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = q.cmd;
    assign sdr_addr  = q.addr;
    assign sdr_bank  = '0;
    assign usr_gnt   = q.gnt;
    assign init_done = q.done;

    // Gap tracking for the timing checks below
    localparam int SINCE_W = $clog2(MAX_B + 2);
    localparam logic [SINCE_W-1:0] SINCE_MAX = '1;

    dram_cmd_e          last_cmd_q;
    logic [SINCE_W-1:0] since_q;
    dram_cmd_e          pin_cmd;

    assign pin_cmd = dram_cmd_e'({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cmd_q <= CMD_NOP;
            since_q    <= '0;
        end else if (pin_cmd != CMD_NOP) begin
            last_cmd_q <= pin_cmd;
            since_q    <= SINCE_W'(1);
        end else if (since_q != SINCE_MAX) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R1: only the four codes this block uses ever reach the pins
    a_r1_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cmd inside {CMD_NOP, CMD_PRE, CMD_REF, CMD_LMR});

    // R3: every precharge closes all banks
    a_r3_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_PRE) |-> (sdr_addr[10] && sdr_bank == '0));

    // R4: spacing after precharge-all and after auto-refresh
    a_r4_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != CMD_NOP && last_cmd_q == CMD_PRE) |-> (since_q >= SINCE_W'(T_RP)));
    a_r4_rc_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != CMD_NOP && last_cmd_q == CMD_REF) |-> (since_q >= SINCE_W'(T_RC)));

    // R5: the mode load carries the configured word on bank 0
    a_r5_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == CMD_LMR) |-> (sdr_addr == mode_word && sdr_bank == '0));

    // R6: done follows the mode load after T_MRD and never drops
    a_r6_done_after_mrd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (last_cmd_q == CMD_LMR && since_q >= SINCE_W'(T_MRD)));
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(init_done));

    // R8 / R9: no grant before init or while a command is on the pins
    a_r8_gnt_needs_init: assert property (@(posedge clk) disable iff (!rst_n)
        usr_gnt |-> init_done);
    a_r9_gnt_yields: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != CMD_NOP) |-> !usr_gnt);

endmodule

// File: tb/test_dram_init_refresh_seq.sv
module test_dram_init_refresh_seq;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 20;
    localparam int RP  = 3;
    localparam int RC  = 6;
    localparam int MRD = 2;
    localparam int IV  = 50;
    localparam int D   = W + RP + 2 * RC + MRD;
    localparam int RUN_END = 300;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        usr_req;
    logic        usr_gnt;
    logic        init_done;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [10:0] addr;
    logic [1:0]  bank;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int          at;
        logic [3:0]  code;
        logic [10:0] a;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_init_refresh_seq #(
        .ADDR_W       (11),
        .BANK_W       (2),
        .INIT_WAIT    (W),
        .T_RP         (RP),
        .T_RC         (RC),
        .T_MRD        (MRD),
        .REF_INTERVAL (IV),
        .BURST_LEN    (8),
        .INTERLEAVE   (1'b0),
        .CAS_LAT      (3),
        .SINGLE_WRITE (1'b1)
    ) i_dram_init_refresh_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .usr_req   (usr_req),
        .usr_gnt   (usr_gnt),
        .init_done (init_done),
        .sdr_cs_n  (cs_n),
        .sdr_ras_n (ras_n),
        .sdr_cas_n (cas_n),
        .sdr_we_n  (we_n),
        .sdr_addr  (addr),
        .sdr_bank  (bank)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic push_expected(input int at, input logic [3:0] code,
                                 input logic [10:0] a, input string req);
        exp_t e;
        e.at = at; e.code = code; e.a = a; e.req = req;
        sb.push_back(e);
    endtask

    function automatic bit req_pattern(input int k);
        if (k >= 10 && k <= 45)   return 1'b1;
        if (k >= 61 && k <= 70)   return k[0];
        if (k >= 80 && k <= 100)  return 1'b1;
        if (k >= 130 && k <= 200) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit in_refresh(input int k);
        int m;
        m = k - D;
        if (m < IV) return 1'b0;
        return (m % IV) < (RP + RC);
    endfunction

    // Driver: stimulus and expected command queue
    initial begin
        rst_n   = 1'b0;
        usr_req = 1'b0;
        // R5 mode word: single write (bit 9), CL 3 = 011 (6:4), sequential, BL 8 = 011
        push_expected(W,               4'b0010, 11'h400, "R3");
        push_expected(W + RP,          4'b0001, 11'h000, "R4");
        push_expected(W + RP + RC,     4'b0001, 11'h000, "R4");
        push_expected(W + RP + 2 * RC, 4'b0000, 11'h233, "R5");
        for (int n = 1; n <= 5; n++) begin
            if (D + n * IV + RP <= RUN_END) begin
                push_expected(D + n * IV,      4'b0010, 11'h400, "R7");
                push_expected(D + n * IV + RP, 4'b0001, 11'h000, "R7");
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R10", "cmd in reset",
              int'({cs_n, ras_n, cas_n, we_n}), 7);
        check(addr == 11'h0 && bank == 2'b0, "R10", "addr/bank in reset", int'(addr), 0);
        check(init_done == 1'b0, "R10", "init_done in reset", int'(init_done), 0);
        check(usr_gnt == 1'b0, "R10", "gnt in reset", int'(usr_gnt), 0);
        rst_n = 1'b1;
        forever begin
            @(negedge clk);
            usr_req = req_pattern(cyc);
        end
    end

    // Monitor: compares pins against scoreboard and grant model
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (cyc >= 1) begin
                logic [3:0] code;
                bit         exp_gnt;
                code = {cs_n, ras_n, cas_n, we_n};
                if (cs_n !== 1'b0) check(1'b0, "R1", "chip select high", int'(code), 7);
                if (code != 4'b0111) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R2", "unexpected command", int'(code), 7);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(cyc == e.at, e.req, "command cycle", cyc, e.at);
                        check(code == e.code, "R1", "command code", int'(code), int'(e.code));
                        check(addr == e.a && bank == 2'b00, e.req, "address",
                              int'({bank, addr}), int'(e.a));
                    end
                end
                // R6: init_done from cycle D onward
                if (cyc == D - 1 || cyc == D || cyc == RUN_END)
                    check(init_done == (cyc >= D), "R6", "init_done", int'(init_done), int'(cyc >= D));
                else if (init_done != (cyc >= D))
                    check(1'b0, "R6", "init_done", int'(init_done), int'(cyc >= D));
                // R8 / R9: grant model
                exp_gnt = req_pattern(cyc - 1) && (cyc >= D) && !in_refresh(cyc);
                check(usr_gnt == exp_gnt, in_refresh(cyc) ? "R9" : "R8", "usr_gnt",
                      int'(usr_gnt), int'(exp_gnt));
            end
            if (cyc >= RUN_END) begin
                check(sb.size() == 0, "R7", "commands still expected", sb.size(), 0);
                finished = 1'b1;
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (RUN_END * 4 + 100) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule